// File: doc/BRIEF.md
# Windowed Key-Sequence Watchdog

This block is a watchdog timer that software must keep alive by writing two key bytes to a service port, first 0x55 and then 0xAA. The completed pair must land inside a timeout period chosen by a 3-bit select. A completed pair restarts the period. If the period runs out, a one-cycle reset request is raised. A write that breaks the key rules also raises the request, on the next cycle.

In window mode the service port only accepts keys during the last quarter of the period. A key written earlier counts as a violation. Every reset request also sets a sticky flag that records that the watchdog caused the reset. Only the block's own asynchronous power-on reset clears this flag.

The period lengths scale with the parameter `BASE_LOG2`, which is 14 by default. Its value is the base-2 logarithm of the shortest period.

Top module: `wwdt_keyed`

## Requirements
- R1: While `rst_n` is low and right after it rises, `rst_req` and `wd_fired` are 0.
- R2: A write of 0x55 followed by a write of 0xAA (both legal) restarts the count. `rst_req` then rises exactly P cycles after the edge that accepted 0xAA, where P is the active period.
- R3: With the watchdog running and no service, `rst_req` is high for exactly one cycle, P clock edges after the count started from zero.
- R4: A service write whose value is neither 0x55 nor 0xAA raises `rst_req` in the cycle after the write.
- R5: Out-of-order keys cause a violation on the cycle after the write: 0xAA with no 0x55 pending, or 0x55 while a 0x55 is already pending.
- R6: With `win_en` = 1, a key written while the count is below P - P/4 raises `rst_req` in the next cycle.
- R7: With `win_en` = 1, a key pair written while the count is at or above P - P/4 is accepted with no reset request.
- R8: When `wd_en` = 0 or `tsel` = 0, the watchdog is stopped, all service writes are ignored and `rst_req` stays 0.
- R9: `wd_fired` goes to 1 together with every `rst_req` pulse. It stays 1 until `rst_n` is asserted.
- R10: `tsel` values 1 to 7 select periods of 2^(B), 2^(B+2), 2^(B+4), 2^(B+6), 2^(B+8), 2^(B+9) and 2^(B+10) cycles, where B = `BASE_LOG2`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| wd_en | input | 1 | Watchdog enable |
| tsel | input | 3 | Timeout select (0 stops the watchdog) |
| win_en | input | 1 | Window mode enable |
| svc_wr | input | 1 | Service write strobe |
| svc_data | input | 8 | Service write data |
| rst_req | output | 1 | One-cycle reset request |
| wd_fired | output | 1 | Sticky flag: watchdog caused a reset |

## Verification
Each write is checked on the clock edge that samples it. Any violation shows on `rst_req` one cycle later, and the bench samples at the falling edge right after that clock edge. Expiry is measured by counting edges from the point where the count was known to be zero: entering the run state, a legal 0xAA, or the previous reset request. The count must equal P exactly. A bench reference model, stepped on the same edges, predicts both outputs every cycle for the random traffic and for the directed cases, so the window boundary at P - P/4 is checked one cycle before the threshold and at the threshold itself.

// File: rtl/wwdt_keyed.sv
module wwdt_keyed #(
  parameter int BASE_LOG2 = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wd_en,
  input  logic [2:0] tsel,
  input  logic       win_en,
  input  logic       svc_wr,
  input  logic [7:0] svc_data,
  output logic       rst_req,
  output logic       wd_fired
);
  localparam int CW = BASE_LOG2 + 11;
  localparam logic [7:0] KEY_A = 8'h55;
  localparam logic [7:0] KEY_B = 8'hAA;

  logic [CW-1:0] cnt, per, open_at;
  logic [3:0]    plog;
  logic          armed, run, late, is_a, is_b, bad, good_b, expire, fire;

  always_comb begin
    case (tsel)
      3'd1:    plog = 4'd0;
      3'd2:    plog = 4'd2;
      3'd3:    plog = 4'd4;
      3'd4:    plog = 4'd6;
      3'd5:    plog = 4'd8;
      3'd6:    plog = 4'd9;
      default: plog = 4'd10;
    endcase
  end

  assign per     = CW'(1) << (BASE_LOG2 + int'(plog));
  assign open_at = per - (per >> 2);
  assign run     = wd_en && (tsel != 3'd0);
  assign late    = cnt >= open_at;
  assign is_a    = svc_data == KEY_A;
  assign is_b    = svc_data == KEY_B;

  assign bad    = run && svc_wr &&
                  (!(is_a || is_b) || (win_en && !late) || (is_b && !armed) || (is_a && armed));
  assign good_b = run && svc_wr && is_b && !bad;
  assign expire = run && !good_b && (cnt >= per - CW'(1));
  assign fire   = bad || expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      armed    <= 1'b0;
      rst_req  <= 1'b0;
      wd_fired <= 1'b0;
    end else begin
      rst_req  <= fire;
      wd_fired <= wd_fired || fire;
      if (!run || fire || good_b) begin
        cnt   <= '0;
        armed <= 1'b0;
      end else begin
        cnt <= cnt + CW'(1);
        if (svc_wr && is_a) armed <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/wwdt_keyed_chk.sv
module wwdt_keyed_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wd_en,
  input logic [2:0] tsel,
  input logic       svc_wr,
  input logic [7:0] svc_data,
  input logic       rst_req,
  input logic       wd_fired
);
  // R4
  bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_en && tsel != 3'd0 && svc_wr && svc_data != 8'h55 && svc_data != 8'hAA) |=> rst_req);

  // R8
  stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wd_en || tsel == 3'd0) |=> !rst_req);

  // R9
  flag_with_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> wd_fired);

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_fired |=> wd_fired);
endmodule

bind wwdt_keyed wwdt_keyed_chk u_chk (.*);

// File: tb/tb_wwdt_keyed.sv
module tb_wwdt_keyed;
  localparam int B = 4;

  logic clk = 1'b0, rst_n = 1'b0, wd_en = 1'b0, win_en = 1'b0, svc_wr = 1'b0;
  logic [2:0] tsel = 3'd0;
  logic [7:0] svc_data = 8'h00;
  logic rst_req, wd_fired;

  int n_chk = 0, n_fail = 0;
  int m_cnt = 0;
  bit m_armed = 0, m_req = 0, m_flag = 0;

  always #2.5 clk = ~clk;

  wwdt_keyed #(.BASE_LOG2(B)) dut (
    .clk(clk), .rst_n(rst_n), .wd_en(wd_en), .tsel(tsel), .win_en(win_en),
    .svc_wr(svc_wr), .svc_data(svc_data), .rst_req(rst_req), .wd_fired(wd_fired));

  function automatic int per_of(logic [2:0] s);
    int off[8] = '{0, 0, 2, 4, 6, 8, 9, 10};
    return 1 << (B + off[s]);
  endfunction

  always @(posedge clk) begin
    int p;
    bit bad, okb;
    if (!rst_n) begin
      m_cnt = 0; m_armed = 0; m_req = 0; m_flag = 0;
    end else if (!wd_en || tsel == 0) begin
      m_cnt = 0; m_armed = 0; m_req = 0;
    end else begin
      p   = per_of(tsel);
      bad = svc_wr && ((svc_data != 8'h55 && svc_data != 8'hAA) ||
                       (win_en && m_cnt < p - p / 4) ||
                       (svc_data == 8'hAA && !m_armed) || (svc_data == 8'h55 && m_armed));
      okb = svc_wr && !bad && svc_data == 8'hAA;
      m_req = bad || (!okb && m_cnt >= p - 1);
      if (m_req || okb) begin
        m_cnt = 0; m_armed = 0;
      end else begin
        m_cnt++;
        if (svc_wr && svc_data == 8'h55) m_armed = 1;
      end
      m_flag = m_flag || m_req;
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(string tag);
    @(posedge clk);
    @(negedge clk);
    chk(rst_req == m_req, {tag, " rst_req"}, int'(rst_req), int'(m_req));
    chk(wd_fired == m_flag, {tag, " wd_fired"}, int'(wd_fired), int'(m_flag));
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic wr(logic [7:0] v, string tag);
    svc_wr = 1; svc_data = v;
    step(tag);
    svc_wr = 0;
  endtask

  task automatic measure(int exp, string tag);
    int k = 0;
    do begin step(tag); k++; end while (!rst_req && k < exp + 5);
    chk(k == exp, {tag, " cycles to reset request"}, k, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
    @(negedge clk);
    idle(3, "R1");
    chk(rst_req == 0 && wd_fired == 0, "R1 in reset", int'(rst_req) + int'(wd_fired), 0);
    rst_n = 1;
    idle(2, "R1");
    chk(rst_req == 0 && wd_fired == 0, "R1 after release", int'(rst_req) + int'(wd_fired), 0);

    wd_en = 1; tsel = 3'd1;
    measure(16, "R3");
    chk(wd_fired == 1, "R9 flag set", int'(wd_fired), 1);
    step("R3");
    chk(rst_req == 0, "R3 single pulse", int'(rst_req), 0);

    rst_n = 0; idle(2, "R9"); rst_n = 1;
    chk(wd_fired == 0, "R9 cleared by power-on reset", int'(wd_fired), 0);
    idle(5, "R2");
    wr(8'h55, "R2"); wr(8'hAA, "R2");
    chk(rst_req == 0, "R2 pair accepted", int'(rst_req), 0);
    measure(16, "R2");

    idle(3, "R4"); wr(8'h12, "R4");
    chk(rst_req == 1, "R4 bad value", int'(rst_req), 1);
    wr(8'hAA, "R5");
    chk(rst_req == 1, "R5 0xAA without 0x55", int'(rst_req), 1);
    wr(8'h55, "R5"); wr(8'h55, "R5");
    chk(rst_req == 1, "R5 double 0x55", int'(rst_req), 1);

    win_en = 1;
    idle(11, "R6"); wr(8'h55, "R6");
    chk(rst_req == 1, "R6 key one cycle before window", int'(rst_req), 1);
    idle(12, "R7"); wr(8'h55, "R7");
    chk(rst_req == 0, "R7 0x55 at window start", int'(rst_req), 0);
    wr(8'hAA, "R7");
    chk(rst_req == 0, "R7 0xAA in window", int'(rst_req), 0);
    measure(16, "R7");
    win_en = 0;

    wd_en = 0; wr(8'h12, "R8"); wr(8'hAA, "R8");
    chk(rst_req == 0, "R8 disabled ignores writes", int'(rst_req), 0);
    wd_en = 1; tsel = 0; wr(8'h00, "R8"); idle(40, "R8");
    chk(rst_req == 0, "R8 tsel 0 stopped", int'(rst_req), 0);

    tsel = 3'd2; measure(64, "R10");
    tsel = 3'd0; step("R10"); tsel = 3'd5; measure(4096, "R10");
    tsel = 3'd0; step("R10"); tsel = 3'd7; measure(16384, "R10");

    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 199) == 0) tsel = 3'($urandom_range(0, 3));
      if ($urandom_range(0, 299) == 0) win_en = ~win_en;
      if ($urandom_range(0, 999) == 0) wd_en = ~wd_en;
      svc_wr = ($urandom_range(0, 5) == 0);
      case ($urandom_range(0, 9))
        0: svc_data = 8'($urandom);
        1, 2, 3, 4: svc_data = 8'h55;
        default: svc_data = 8'hAA;
      endcase
      step("R2/R4/R5/R6/R7 random");
    end
    svc_wr = 0;

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule